// File: doc/BRIEF.md
# Distributed Instruction-Cache Refill Coordinator

This block is the control-tile logic that decides, for each block fetch, whether the instruction cache already holds the target line. It keeps a tag and a valid bit for every line of a direct-mapped index. When a lookup hits, the block offers dispatch for that block straight away. When it misses, it broadcasts the block-aligned refill address to all instruction tiles at once. Each tile fills its own part of the line independently and sends back one completion pulse. Dispatch is released only after every tile has answered, which forms an all-tiles barrier.

The lookup input is a valid/ready stream. `lk_ready` is high only while the coordinator is idle, so a second miss waits, stalled at the port, until the first refill and its dispatch have completed. The dispatch output is also a valid/ready stream. Once `disp_valid` rises, it and `disp_addr` hold until `disp_ready` is sampled high.

The refill broadcast is a one-cycle pulse with no back-pressure, because the tiles always accept it. Tile completions arrive on plain pulse pins, one bit per tile. The line's valid bit and tag are written only when the barrier completes, never at miss time. That write also appears at the ports as a one-cycle update pulse with the index and tag.

Top module: `icache_refill_coord`

## Requirements
- R1: After reset, `lk_ready`=1, `rf_valid`=0, `disp_valid`=0 and `tag_wr_en`=0, and every line is invalid, so the first lookup of any address misses.
- R2: A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. If it hits (line valid and stored tag equal to `lk_addr[31:11]`, index `lk_addr[10:7]`), `disp_valid` is high from the next cycle with `disp_addr` = `{lk_addr[31:7], 7'b0}`, and no refill pulse is raised.
- R3: An accepted lookup that misses raises `rf_valid` for exactly one cycle, the cycle after acceptance, with `rf_addr` = `{lk_addr[31:7], 7'b0}`.
- R4: After a miss, `disp_valid` stays low until each of the five tiles has pulsed its own bit of `tile_done` (bit i for tile i), in any order and with any gaps. It rises in the cycle after the edge that samples the last missing bit.
- R5: A completion pulse for a tile whose bit is already clear has no effect. This covers pulses received while idle, while dispatch is waiting, and repeats during a refill. A new miss always waits for all five tiles.
- R6: `tag_wr_en` pulses for one cycle, in the first cycle of `disp_valid` after a refill, with `tag_wr_idx`/`tag_wr_tag` giving the filled line. It is never raised for a hit.
- R7: `lk_ready` is low from the cycle after an accepted lookup until the cycle after the dispatch handshake, so at most one refill is outstanding.
- R8: While `disp_valid`=1 and `disp_ready`=0, `disp_valid` and `disp_addr` hold. The handshake edge returns the block to idle.
- R9: A miss to an index that already holds a different tag replaces it, so a later lookup with the old tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Coordinator idle and able to take a lookup |
| lk_addr | input | 32 | Fetch block byte address |
| rf_valid | output | 1 | One-cycle refill broadcast to all tiles |
| rf_addr | output | 32 | Block-aligned refill address |
| tile_done | input | 5 | Per-tile refill completion pulses |
| tag_wr_en | output | 1 | Tag/valid update pulse at barrier completion |
| tag_wr_idx | output | 4 | Index of the updated line |
| tag_wr_tag | output | 21 | Tag written to the line |
| disp_valid | output | 1 | Dispatch permitted for the current block |
| disp_ready | input | 1 | Dispatch taken |
| disp_addr | output | 32 | Block-aligned address of the dispatched block |

## Verification
The hardest situation to reach from the ports is a completion pulse that must be ignored while the barrier is partly drained. In that case a tile that has already finished pulses again, possibly in the same cycle as a tile that is still pending, just before the last tile answers. The stimulus shuffles the tile order for every miss and inserts random gaps. It randomly ORs a finished tile's bit into later pulses and adds stand-alone repeat pulses. After each such pulse it checks that dispatch is still withheld. A small address pool with two tags per index makes hits, misses and replacements of the same line alternate.

// File: rtl/icr_pkg.sv
package icr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } icr_state_e;
endpackage

// File: rtl/icr_tag_store.sv
module icr_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] line_vld;
  logic [TAG_W-1:0] line_tag [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_vld[g] <= 1'b0;
        line_tag[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        line_vld[g] <= 1'b1;
        line_tag[g] <= wr_tag;
      end
    end
  end

  assign rd_valid = line_vld[rd_idx];
  assign rd_tag   = line_tag[rd_idx];
endmodule

// File: rtl/icr_hit_check.sv
module icr_hit_check #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              line_valid,
  input  logic [TAG_W-1:0]  line_tag,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag,
  output logic              hit
);
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
  assign hit = line_valid && (line_tag == tag);
endmodule

// File: rtl/icr_barrier.sv
module icr_barrier #(
  parameter int N_TILE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              collect,
  input  logic [N_TILE-1:0] done_in,
  output logic [N_TILE-1:0] pending,
  output logic              complete
);
  for (genvar t = 0; t < N_TILE; t++) begin : g_tile
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pending[t] <= 1'b0;
      else if (arm)                   pending[t] <= 1'b1;
      else if (collect && done_in[t]) pending[t] <= 1'b0;
    end
  end

  assign complete = collect && (|pending) && ~|(pending & ~done_in);

  AST_MASK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ((pending & ~$past(pending)) == '0)); // R5
  AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !arm) |=> (pending == '0)); // R4
endmodule

// File: rtl/icache_refill_coord.sv
module icache_refill_coord
  import icr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  parameter int IDX_W  = 4,
  parameter int N_TILE = 5,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int BLK_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rf_valid,
  output logic [ADDR_W-1:0] rf_addr,
  input  logic [N_TILE-1:0] tile_done,
  output logic              tag_wr_en,
  output logic [IDX_W-1:0]  tag_wr_idx,
  output logic [TAG_W-1:0]  tag_wr_tag,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [ADDR_W-1:0] disp_addr
);
  icr_state_e        state;
  logic [BLK_W-1:0]  cur_blk;
  logic              accept, hit, complete, line_valid;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag, line_tag;
  logic [N_TILE-1:0] pending;

  assign lk_ready = (state == ST_IDLE);
  assign accept   = lk_valid && lk_ready;

  icr_hit_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_hit (
    .addr(lk_addr), .line_valid(line_valid), .line_tag(line_tag),
    .idx(lk_idx), .tag(lk_tag), .hit(hit)
  );

  assign tag_wr_idx = cur_blk[IDX_W-1:0];
  assign tag_wr_tag = cur_blk[BLK_W-1 -: TAG_W];

  icr_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(line_valid), .rd_tag(line_tag),
    .wr_en(complete), .wr_idx(tag_wr_idx), .wr_tag(tag_wr_tag)
  );

  icr_barrier #(.N_TILE(N_TILE)) u_bar (
    .clk(clk), .rst_n(rst_n),
    .arm(accept && !hit), .collect(state == ST_FILL),
    .done_in(tile_done), .pending(pending), .complete(complete)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_blk   <= '0;
      rf_valid  <= 1'b0;
      tag_wr_en <= 1'b0;
    end else begin
      rf_valid  <= 1'b0;
      tag_wr_en <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          cur_blk <= lk_addr[ADDR_W-1:OFF_W];
          if (hit) state <= ST_SEND;
          else begin
            state    <= ST_FILL;
            rf_valid <= 1'b1;
          end
        end
        ST_FILL: if (complete) begin
          state     <= ST_SEND;
          tag_wr_en <= 1'b1;
        end
        ST_SEND: if (disp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rf_addr    = {cur_blk, {OFF_W{1'b0}}};
  assign disp_addr  = {cur_blk, {OFF_W{1'b0}}};
  assign disp_valid = (state == ST_SEND);

  AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |=> !rf_valid); // R3
  AST_TAG_WITH_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> disp_valid); // R6
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid || (pending != '0)) |-> !lk_ready); // R7
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_addr))); // R8
  AST_NO_EARLY_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> !disp_valid); // R4
endmodule

// File: tb/tb_icache_refill_coord.sv
module tb_icache_refill_coord;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_ready;
  logic [31:0] lk_addr = '0;
  logic        rf_valid;
  logic [31:0] rf_addr;
  logic [4:0]  tile_done = '0;
  logic        tag_wr_en;
  logic [3:0]  tag_wr_idx;
  logic [20:0] tag_wr_tag;
  logic        disp_valid, disp_ready = 1'b0;
  logic [31:0] disp_addr;

  int total = 0, bad = 0;
  logic        mv [16];
  logic [20:0] mt [16];

  always #10 clk = ~clk;

  icache_refill_coord dut (.*);

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(input logic [31:0] a);
    return mv[a[10:7]] && (mt[a[10:7]] == a[31:11]);
  endfunction

  task automatic run_lookup(input logic [31:0] a, output bit missed);
    logic [31:0] blk = {a[31:7], 7'b0};
    bit hit = model_hit(a);
    int ord [5];
    @(negedge clk);
    chk(lk_ready == 1'b1, "R7 idle ready", 32'(lk_ready), 1);
    lk_valid = 1'b1; lk_addr = a;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    missed = rf_valid;
    chk(rf_valid == !hit, "R2/R3 refill on miss only", 32'(rf_valid), 32'(!hit));
    chk(lk_ready == 1'b0, "R7 busy after accept", 32'(lk_ready), 0);
    if (hit) begin
      chk(disp_valid == 1'b1, "R2 hit dispatch", 32'(disp_valid), 1);
      chk(tag_wr_en == 1'b0, "R6 no tag write on hit", 32'(tag_wr_en), 0);
    end else begin
      chk(rf_addr == blk, "R3 refill address", rf_addr, blk);
      for (int i = 0; i < 5; i++) ord[i] = i;
      for (int i = 4; i > 0; i--) begin
        int j = int'($urandom % (i + 1));
        int tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
      end
      for (int k = 0; k < 5; k++) begin
        int gap = int'($urandom % 3);
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk(disp_valid == 1'b0, "R4 wait in gap", 32'(disp_valid), 0);
          chk(rf_valid == 1'b0, "R3 single pulse", 32'(rf_valid), 0);
        end
        tile_done = 5'(1 << ord[k]);
        if (k > 0 && ($urandom % 3) == 0) tile_done |= 5'(1 << ord[0]);
        @(posedge clk); @(negedge clk);
        tile_done = '0;
        if (k < 4) begin
          chk(disp_valid == 1'b0, "R4 barrier open early", 32'(disp_valid), 0);
          chk(tag_wr_en == 1'b0, "R6 early tag write", 32'(tag_wr_en), 0);
          if (($urandom % 3) == 0) begin
            tile_done = 5'(1 << ord[k]);
            @(posedge clk); @(negedge clk);
            tile_done = '0;
            chk(disp_valid == 1'b0, "R5 repeat pulse ignored", 32'(disp_valid), 0);
          end
        end else begin
          chk(disp_valid == 1'b1, "R4 barrier release", 32'(disp_valid), 1);
          chk(tag_wr_en == 1'b1, "R6 tag write at release", 32'(tag_wr_en), 1);
          chk(tag_wr_idx == a[10:7], "R6 tag index", 32'(tag_wr_idx), 32'(a[10:7]));
          chk(tag_wr_tag == a[31:11], "R6 tag value", 32'(tag_wr_tag), 32'(a[31:11]));
          mv[a[10:7]] = 1'b1; mt[a[10:7]] = a[31:11];
        end
      end
    end
    chk(disp_addr == blk, "R2 dispatch address", disp_addr, blk);
    for (int s = 0; s < int'($urandom % 3); s++) begin
      if (($urandom % 2) == 0) tile_done = 5'h1F;
      @(posedge clk); @(negedge clk);
      tile_done = '0;
      chk(disp_valid == 1'b1 && disp_addr == blk, "R8 hold under stall", disp_addr, blk);
      chk(tag_wr_en == 1'b0, "R6 single tag pulse", 32'(tag_wr_en), 0);
    end
    disp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    disp_ready = 1'b0;
    chk(disp_valid == 1'b0, "R8 handshake ends dispatch", 32'(disp_valid), 0);
    chk(lk_ready == 1'b1, "R7 ready after handshake", 32'(lk_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit m;
    void'($urandom(32'h51C3));
    for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    chk(lk_ready == 1'b1 && rf_valid == 1'b0, "R1 reset idle", {lk_ready, rf_valid}, 2);
    chk(disp_valid == 1'b0 && tag_wr_en == 1'b0, "R1 reset outputs", {disp_valid, tag_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    tile_done = 5'h1F;                         // R5: pulses while idle
    @(posedge clk); @(negedge clk);
    tile_done = '0;
    run_lookup(32'h0000_1280, m);
    chk(m == 1'b1, "R1 first lookup misses", 32'(m), 1);
    run_lookup(32'h0000_12C4, m);
    chk(m == 1'b0, "R2 same block hits", 32'(m), 0);
    run_lookup(32'h00AB_1280, m);
    chk(m == 1'b1, "R9 other tag misses", 32'(m), 1);
    run_lookup(32'h0000_1280, m);
    chk(m == 1'b1, "R9 replaced tag misses", 32'(m), 1);
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a;
      a = {10'h0, 11'($urandom % 2) * 11'h155, 4'($urandom % 4) * 4'd3, 7'($urandom)};
      run_lookup(a, m);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule